// File: doc/BRIEF.md
# Gray-Coded X/Y Pixel Address Latch

This block selects one pixel of a square sensor matrix by random access. A column address and a row address arrive in Gray code on two separate buses, so that stepping to a neighbouring line toggles only one wire. Each bus has its own capture strobe. The two strobes may fire on the same clock edge or on different edges. Each captured code is turned into a binary line index, and that index drives a one-hot select vector for the columns or for the rows.

The block also reports whether the selected pixel lies in the imaging window. Indices below the window, above it, and up to the last implemented line address test rows and covered reference pixels that are used for calibration. An index beyond the last implemented line raises a per-axis error flag, and that axis drives no select line.

A small state machine tracks which axes have been loaded since reset. It has four states:
- `ST_NONE`: neither axis loaded.
- `ST_X_ONLY`: only the column address loaded.
- `ST_Y_ONLY`: only the row address loaded.
- `ST_BOTH`: both addresses loaded.

The transitions are:
- `ST_NONE` to `ST_X_ONLY` on a column strobe alone.
- `ST_NONE` to `ST_Y_ONLY` on a row strobe alone.
- `ST_NONE` to `ST_BOTH` on both strobes together.
- `ST_X_ONLY` to `ST_BOTH` on a row strobe.
- `ST_Y_ONLY` to `ST_BOTH` on a column strobe.

`ST_BOTH` is kept until reset. Every other state holds when no strobe that would advance it is present.

Top module: `pix_xy_addr_latch`

## Requirements
- R1: After reset, both select vectors are all-zero, both error flags are low and the in-window flag is low.
- R2: On a clock edge where `col_load` is high, the column Gray code is captured. After that edge, `col_sel` has exactly bit b set, where b is the binary value of the code (bit i of b is the XOR of code bits i through 9).
- R3: On a clock edge where `row_load` is high, the row Gray code is captured with the same conversion as R2, and `row_sel` has exactly bit b set.
- R4: A strobe on one axis leaves the other axis's select vector and error flag unchanged.
- R5: When both strobes are high on the same edge, both addresses are captured on that edge.
- R6: While an axis's strobe is low, changes on its Gray bus have no effect on its select vector or error flag.
- R7: `in_window` is high exactly when both axes are loaded and both binary indices lie in 2..658 inclusive. Indices 0, 1 and 659 are calibration lines.
- R8: A binary index above 659 (the last implemented line) sets that axis's error flag and leaves its select vector all-zero. Indices 0..659 clear the flag.
- R9: Each select vector has at most one bit set at any time.
- R10: `in_window` stays low until both axes have been loaded at least once since reset, and the loaded state is kept until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_gray | input | 10 | Column address, Gray code |
| col_load | input | 1 | Column capture strobe |
| row_gray | input | 10 | Row address, Gray code |
| row_load | input | 1 | Row capture strobe |
| col_sel | output | 660 | One-hot column select |
| row_sel | output | 660 | One-hot row select |
| col_err | output | 1 | Column index beyond the last implemented line |
| row_err | output | 1 | Row index beyond the last implemented line |
| in_window | output | 1 | Selected pixel lies in the imaging window |

## Verification
Every result is due on the first clock edge that samples a strobe. The captured index is registered, and the selects, error flags and window flag are decoded from it without a further register. The bench therefore drives the buses and strobes on a falling edge and drops the strobes on the next falling edge. It checks all outputs at that point, half a cycle after the capturing edge. Hold checks change the buses with the strobes low and then look one full cycle later, after an edge that could have captured the new value.

// File: rtl/pix_xy_pkg.sv
package pix_xy_pkg;

    // Which address axes have been loaded since reset.
    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_X_ONLY = 2'd1,
        ST_Y_ONLY = 2'd2,
        ST_BOTH   = 2'd3
    } pair_state_t;

endpackage

// File: rtl/pix_gray_to_bin.sv
module pix_gray_to_bin #(
    parameter int W = 10
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);

    // The MSB passes through. Each lower bit folds in every bit above it.
    assign bin[W-1] = gray[W-1];

    generate
        for (genvar i = W - 2; i >= 0; i--) begin : g_fold
            assign bin[i] = bin[i+1] ^ gray[i];
        end
    endgenerate

endmodule

// File: rtl/pix_axis_reg.sv
module pix_axis_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] gray,
    output logic [W-1:0] idx
);

    logic [W-1:0] bin_now;

    pix_gray_to_bin #(.W(W)) u_conv (
        .gray (gray),
        .bin  (bin_now)
    );

    // Convert before the register, so the stored index is already binary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= bin_now;
        end
    end

    // R6: without a strobe the stored index does not move.
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(idx));

endmodule

// File: rtl/pix_line_decoder.sv
module pix_line_decoder #(
    parameter int W     = 10,
    parameter int LINES = 660
) (
    input  logic [W-1:0]     idx,
    input  logic             en,
    output logic [LINES-1:0] sel,
    output logic             err
);

    localparam logic [W-1:0] LAST = W'(LINES - 1);

    // Out-of-range flag, raised only for an axis that has been loaded.
    assign err = en && (idx > LAST);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            assign sel[g] = en && (idx == W'(g));
        end
    endgenerate

    // R9: at most one line is selected.
    always_comb begin
        a_onehot_r9: assert ($onehot0(sel));
    end

    // R8: an error means no select line is driven.
    always_comb begin
        if (err) a_err_quiet_r8: assert (sel == '0);
    end

endmodule

// File: rtl/pix_xy_addr_latch.sv
module pix_xy_addr_latch
    import pix_xy_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LINES  = 660,
    parameter int ACT_LO = 2,
    parameter int ACT_HI = 658
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] col_gray,
    input  logic              col_load,
    input  logic [ADDR_W-1:0] row_gray,
    input  logic              row_load,
    output logic [LINES-1:0]  col_sel,
    output logic [LINES-1:0]  row_sel,
    output logic              col_err,
    output logic              row_err,
    output logic              in_window
);

    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(ACT_LO);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(ACT_HI);

    pair_state_t state_q, state_d;
    logic [ADDR_W-1:0] col_idx, row_idx;
    logic col_held, row_held;
    logic col_in, row_in;

    // ---------------- datapath per axis ----------------
    pix_axis_reg #(.W(ADDR_W)) u_col_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (col_load),
        .gray  (col_gray),
        .idx   (col_idx)
    );

    pix_axis_reg #(.W(ADDR_W)) u_row_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (row_load),
        .gray  (row_gray),
        .idx   (row_idx)
    );

    pix_line_decoder #(.W(ADDR_W), .LINES(LINES)) u_col_dec (
        .idx (col_idx),
        .en  (col_held),
        .sel (col_sel),
        .err (col_err)
    );

    pix_line_decoder #(.W(ADDR_W), .LINES(LINES)) u_row_dec (
        .idx (row_idx),
        .en  (row_held),
        .sel (row_sel),
        .err (row_err)
    );

    // ---------------- load-tracking state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NONE: begin
                if (col_load && row_load) state_d = ST_BOTH;
                else if (col_load)        state_d = ST_X_ONLY;
                else if (row_load)        state_d = ST_Y_ONLY;
            end
            ST_X_ONLY: if (row_load) state_d = ST_BOTH;
            ST_Y_ONLY: if (col_load) state_d = ST_BOTH;
            ST_BOTH:   state_d = ST_BOTH;
            default:   state_d = ST_NONE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        col_held = 1'b0;
        row_held = 1'b0;
        unique case (state_q)
            ST_NONE:   ;
            ST_X_ONLY: col_held = 1'b1;
            ST_Y_ONLY: row_held = 1'b1;
            ST_BOTH: begin
                col_held = 1'b1;
                row_held = 1'b1;
            end
            default:   ;
        endcase
    end

    // ---------------- window classification ----------------
    assign col_in    = (col_idx >= WIN_LO) && (col_idx <= WIN_HI);
    assign row_in    = (row_idx >= WIN_LO) && (row_idx <= WIN_HI);
    assign in_window = col_held && row_held && col_in && row_in;

    // ---------------- assertions ----------------
    // R10: once both axes are loaded, that stays so until reset.
    p_both_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOTH) |=> (state_q == ST_BOTH));

    // R7: a pixel in the window has a valid line on each axis.
    p_window_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> (!col_err && !row_err
                       && $countones(col_sel) == 1 && $countones(row_sel) == 1));

    // R4: a row strobe alone does not disturb the column select.
    p_col_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_load && !col_load && state_q != ST_NONE && state_q != ST_Y_ONLY)
            |=> $stable(col_sel));

    // R6: without a column strobe the column outputs hold.
    p_col_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !col_load |=> ($stable(col_sel) && $stable(col_err)));

    // R6: without a row strobe the row outputs hold.
    p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !row_load |=> ($stable(row_sel) && $stable(row_err)));

endmodule

// File: tb/pix_xy_addr_latch_tb.sv
module pix_xy_addr_latch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int LINES      = 660;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] col_gray = '0, row_gray = '0;
    logic col_load = 1'b0, row_load = 1'b0;
    logic [LINES-1:0] col_sel, row_sel;
    logic col_err, row_err, in_window;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_xy_addr_latch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_gray  (col_gray),
        .col_load  (col_load),
        .row_gray  (row_gray),
        .row_load  (row_load),
        .col_sel   (col_sel),
        .row_sel   (row_sel),
        .col_err   (col_err),
        .row_err   (row_err),
        .in_window (in_window)
    );

    function automatic logic [W-1:0] enc(int b);
        logic [W-1:0] v = W'(b);
        return v ^ (v >> 1);
    endfunction

    // Expected index, or -1 for an all-zero vector; -2 flags a non-one-hot vector.
    function automatic int sel_index(logic [LINES-1:0] s);
        int n = $countones(s);
        if (n == 0) return -1;
        if (n > 1)  return -2;
        for (int i = 0; i < LINES; i++) if (s[i]) return i;
        return -2;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected select index for a loaded axis holding index b.
    function automatic int exp_sel(int b);
        return (b > LINES - 1) ? -1 : b;
    endfunction

    function automatic int in_win(int b);
        return (b >= 2 && b <= 658) ? 1 : 0;
    endfunction

    // Drive on a falling edge. The next rising edge captures; check on the falling edge after that.
    task automatic apply(bit xs, int xb, bit ys, int yb);
        @(negedge clk);
        col_gray = enc(xb); col_load = xs;
        row_gray = enc(yb); row_load = ys;
        @(negedge clk);
        col_load = 1'b0; row_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "col_sel", sel_index(col_sel), -1);
        chk("R1", "row_sel", sel_index(row_sel), -1);
        chk("R1", "errs", int'(col_err) + int'(row_err), 0);
        chk("R1", "in_window", int'(in_window), 0);

        // R2/R10: column alone
        apply(1, 100, 0, 0);
        chk("R2", "col_sel", sel_index(col_sel), 100);
        chk("R4", "row_sel untouched", sel_index(row_sel), -1);
        chk("R10", "in_window one axis", int'(in_window), 0);

        // R3/R4: row alone afterwards
        apply(0, 0, 1, 200);
        chk("R3", "row_sel", sel_index(row_sel), 200);
        chk("R4", "col_sel kept", sel_index(col_sel), 100);
        chk("R7", "in_window", int'(in_window), 1);

        // R6: buses move with strobes low
        @(negedge clk);
        col_gray = enc(5); row_gray = enc(700);
        @(negedge clk);
        chk("R6", "col_sel held", sel_index(col_sel), 100);
        chk("R6", "row_sel held", sel_index(row_sel), 200);
        chk("R6", "row_err held", int'(row_err), 0);

        // R5: both strobes on the same edge
        apply(1, 5, 1, 7);
        chk("R5", "col_sel", sel_index(col_sel), 5);
        chk("R5", "row_sel", sel_index(row_sel), 7);

        // Column sweep over every code, row fixed in the window
        apply(0, 0, 1, 300);
        for (int b = 0; b < (1 << W); b++) begin
            apply(1, b, 0, 0);
            chk("R2", "col_sel sweep", sel_index(col_sel), exp_sel(b));
            chk("R8", "col_err sweep", int'(col_err), (b > LINES - 1) ? 1 : 0);
            chk("R7", "in_window col sweep", int'(in_window), in_win(b));
            chk("R9", "row_sel one-hot", sel_index(row_sel), 300);
        end

        // Row sweep over every code, column fixed in the window
        apply(1, 300, 0, 0);
        for (int b = 0; b < (1 << W); b++) begin
            apply(0, 0, 1, b);
            chk("R3", "row_sel sweep", sel_index(row_sel), exp_sel(b));
            chk("R8", "row_err sweep", int'(row_err), (b > LINES - 1) ? 1 : 0);
            chk("R7", "in_window row sweep", int'(in_window), in_win(b));
            chk("R4", "col_sel kept", sel_index(col_sel), 300);
        end

        // R10: after a fresh reset a single axis is not enough
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        apply(0, 0, 1, 400);
        chk("R10", "in_window row only", int'(in_window), 0);
        chk("R1", "col_sel after reset", sel_index(col_sel), -1);
        apply(1, 2, 0, 0);
        chk("R10", "in_window both", int'(in_window), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule